// File: doc/BRIEF.md
# Byte-Lane Odd Parity Guard

This block sits on the 32-bit data path between two bus ports and a memory array. On the write side it adds one odd-parity bit to each data byte and passes the lane enables on, so the array receives a 36-bit word in which only the addressed lanes change. On the read side it takes the 36-bit word that the array returns and checks parity on the lanes that the transfer uses. It then presents the data with an acknowledge, or ends the transfer with an error on the port that made the read.

For diagnostics, a wrong-parity input inverts every generated parity bit. A sticky error flag records any read parity mismatch, whether or not reporting is enabled. The shared bus can clear the flag by writing zero to it, or set it by writing one. Each byte lane `i` of the stored word occupies bits `9*i+7 .. 9*i`, and its parity bit sits at bit `9*i+8`.

Top module: `byte_parity_guard`

## Requirements
- R1: One cycle after `wr_en`, `mem_wr_en` is 1, `mem_wr_lanes` equals `wr_lanes`, and each lane of `mem_wr_word` holds its data byte. Its parity bit is chosen so that the byte plus the parity bit contain an odd number of ones.
- R2: When `inj_wrong` is 1 during a write, every parity bit of `mem_wr_word` is the inverse of the value R1 gives.
- R3: A partial write changes only the lanes set in `wr_lanes`. An array that honours `mem_wr_lanes` keeps the data and parity of the other lanes, and a later full read returns the old bytes in those lanes with no error.
- R4: A read reports a mismatch only if a lane enabled in `rd_lanes` fails odd parity. A bad parity bit in a disabled lane has no effect.
- R5: One cycle after `rd_vld`, `rd_data` carries the four data bytes, and exactly one of `rd_ack`, `bus_err` and `mem_err` is 1. Without `rd_vld`, all three are 0.
- R6: A mismatch with `rpt_en` = 1 ends the read with `bus_err` when `rd_port` = 0 (shared bus), or with `mem_err` when `rd_port` = 1 (local bus), and does not raise `rd_ack`.
- R7: A mismatch with `rpt_en` = 0 ends the read with a normal `rd_ack`.
- R8: A mismatch sets `err_flag` in the cycle the read result appears, whatever `rpt_en` is. The flag then stays set until it is cleared.
- R9: `flag_wr_en` with `flag_wr_val` = 0 clears `err_flag`, and with `flag_wr_val` = 1 sets it. If a mismatch is detected in the same cycle as a clear, the flag ends set.
- R10: After a synchronous reset, `err_flag`, `rd_ack`, `bus_err`, `mem_err` and `mem_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_wrong | input | 1 | Invert generated parity on writes |
| rpt_en | input | 1 | Signal read parity errors to the requesting port |
| flag_wr_en | input | 1 | Shared-bus write strobe for the error flag |
| flag_wr_val | input | 1 | Value written to the error flag |
| wr_en | input | 1 | Write request |
| wr_lanes | input | 4 | Byte lanes written |
| wr_data | input | 32 | Write data |
| mem_wr_en | output | 1 | Write strobe to the array |
| mem_wr_lanes | output | 4 | Lane enables to the array |
| mem_wr_word | output | 36 | Data plus parity to the array |
| rd_vld | input | 1 | Array read word valid |
| rd_port | input | 1 | Requesting port: 0 shared bus, 1 local bus |
| rd_lanes | input | 4 | Byte lanes the read uses |
| mem_rd_word | input | 36 | Data plus parity from the array |
| rd_data | output | 32 | Read data |
| rd_ack | output | 1 | Normal read termination |
| bus_err | output | 1 | Error termination on the shared bus |
| mem_err | output | 1 | Error termination on the local bus |
| err_flag | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume that a clean read, or a write, is not followed by a spurious response. They also assume that `rd_port`, `rpt_en` and `rd_lanes` are held steady with `rd_vld` for the cycle it is sampled. The combination of `inj_wrong` and `rpt_en` both at 1 is treated as outside the supported use. The stimulus never drives that pair together: the wrong-parity sweep runs with reporting off, and every read sweep keeps `inj_wrong` at 0. Corrupted stored words are built directly by the bench, by flipping chosen parity bits.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef enum logic {PORT_SHARED = 1'b0, PORT_LOCAL = 1'b1} port_e;
endpackage

// File: rtl/bpg_encode.sv
module bpg_encode #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW = LANES * BYTE_W,
  localparam int SW = LANES * (BYTE_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [DW-1:0]    wr_data,
  input  logic             inj,
  output logic             mem_wr_en,
  output logic [LANES-1:0] mem_wr_lanes,
  output logic [SW-1:0]    mem_wr_word
);
  logic [SW-1:0] word_c;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      // odd parity: the stored bit makes the count of ones odd
      assign word_c[g*(BYTE_W+1) +: BYTE_W] = wr_data[g*BYTE_W +: BYTE_W];
      assign word_c[g*(BYTE_W+1) + BYTE_W]  = ~(^wr_data[g*BYTE_W +: BYTE_W]) ^ inj;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_en    <= 1'b0;
      mem_wr_lanes <= '0;
      mem_wr_word  <= '0;
    end else begin
      mem_wr_en <= wr_en;
      if (wr_en) begin
        mem_wr_lanes <= wr_lanes;
        mem_wr_word  <= word_c;
      end
    end
  end
endmodule

// File: rtl/bpg_check.sv
module bpg_check #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW = LANES * BYTE_W,
  localparam int SW = LANES * (BYTE_W + 1)
) (
  input  logic [SW-1:0]    word,
  input  logic [LANES-1:0] lanes,
  output logic [LANES-1:0] lane_bad,
  output logic [DW-1:0]    data
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign data[g*BYTE_W +: BYTE_W] = word[g*(BYTE_W+1) +: BYTE_W];
      // a good lane has odd weight over its nine bits
      assign lane_bad[g] = lanes[g] & ~(^word[g*(BYTE_W+1) +: BYTE_W+1]);
    end
  endgenerate
endmodule

// File: rtl/bpg_flag.sv
module bpg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (wr_en)   flag <= wr_val;
  end
endmodule

// File: rtl/byte_parity_guard.sv
module byte_parity_guard #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW = LANES * BYTE_W,
  localparam int SW = LANES * (BYTE_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inj_wrong,
  input  logic             rpt_en,
  input  logic             flag_wr_en,
  input  logic             flag_wr_val,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [DW-1:0]    wr_data,
  output logic             mem_wr_en,
  output logic [LANES-1:0] mem_wr_lanes,
  output logic [SW-1:0]    mem_wr_word,
  input  logic             rd_vld,
  input  logic             rd_port,
  input  logic [LANES-1:0] rd_lanes,
  input  logic [SW-1:0]    mem_rd_word,
  output logic [DW-1:0]    rd_data,
  output logic             rd_ack,
  output logic             bus_err,
  output logic             mem_err,
  output logic             err_flag
);
  import bpg_pkg::*;

  logic [LANES-1:0] lane_bad;
  logic [DW-1:0]    rd_data_c;
  logic             hit;
  logic             report;
  port_e            port;

  bpg_encode #(.LANES(LANES), .BYTE_W(BYTE_W)) u_enc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lanes(wr_lanes),
    .wr_data(wr_data), .inj(inj_wrong), .mem_wr_en(mem_wr_en),
    .mem_wr_lanes(mem_wr_lanes), .mem_wr_word(mem_wr_word)
  );

  bpg_check #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
    .word(mem_rd_word), .lanes(rd_lanes), .lane_bad(lane_bad), .data(rd_data_c)
  );

  assign hit    = rd_vld & (|lane_bad);
  assign report = hit & rpt_en;
  assign port   = port_e'(rd_port);

  bpg_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(hit), .wr_en(flag_wr_en),
    .wr_val(flag_wr_val), .flag(err_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
      bus_err <= 1'b0;
      mem_err <= 1'b0;
    end else begin
      if (rd_vld) rd_data <= rd_data_c;
      rd_ack  <= rd_vld & ~report;
      bus_err <= report & (port == PORT_SHARED);
      mem_err <= report & (port == PORT_LOCAL);
    end
  end
endmodule

// File: rtl/bpg_sva.sv
module bpg_sva (
  input logic clk,
  input logic rst,
  input logic rpt_en,
  input logic flag_wr_en,
  input logic wr_en,
  input logic mem_wr_en,
  input logic rd_vld,
  input logic rd_port,
  input logic rd_ack,
  input logic bus_err,
  input logic mem_err,
  input logic err_flag
);
  AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (rst) wr_en |=> mem_wr_en); // R1
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (rst) $onehot0({rd_ack, bus_err, mem_err})); // R5
  AST_RESP_AFTER_RD: assert property (@(posedge clk) disable iff (rst) rd_vld |=> (rd_ack || bus_err || mem_err)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !rd_vld |=> !(rd_ack || bus_err || mem_err)); // R5
  AST_SHARED_PORT: assert property (@(posedge clk) disable iff (rst) (rd_vld && !rd_port) |=> !mem_err); // R6
  AST_LOCAL_PORT: assert property (@(posedge clk) disable iff (rst) (rd_vld && rd_port) |=> !bus_err); // R6
  AST_SILENT_WO_RPT: assert property (@(posedge clk) disable iff (rst) !rpt_en |=> !(bus_err || mem_err)); // R7
  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (rst) (bus_err || mem_err) |-> err_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (err_flag && !flag_wr_en) |=> err_flag); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> !(err_flag || rd_ack || bus_err || mem_err || mem_wr_en)); // R10
endmodule

bind byte_parity_guard bpg_sva u_sva (
  .clk(clk), .rst(rst), .rpt_en(rpt_en), .flag_wr_en(flag_wr_en),
  .wr_en(wr_en), .mem_wr_en(mem_wr_en), .rd_vld(rd_vld), .rd_port(rd_port),
  .rd_ack(rd_ack), .bus_err(bus_err), .mem_err(mem_err), .err_flag(err_flag)
);

// File: tb/sim_byte_parity_guard.sv
module sim_byte_parity_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inj_wrong = 0, rpt_en = 0, flag_wr_en = 0, flag_wr_val = 0;
  logic wr_en = 0;
  logic [3:0] wr_lanes = '0;
  logic [31:0] wr_data = '0;
  logic mem_wr_en;
  logic [3:0] mem_wr_lanes;
  logic [35:0] mem_wr_word;
  logic rd_vld = 0, rd_port = 0;
  logic [3:0] rd_lanes = '0;
  logic [35:0] mem_rd_word = '0;
  logic [31:0] rd_data;
  logic rd_ack, bus_err, mem_err, err_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  byte_parity_guard u0 (
    .clk(clk), .rst(rst), .inj_wrong(inj_wrong), .rpt_en(rpt_en),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val), .wr_en(wr_en),
    .wr_lanes(wr_lanes), .wr_data(wr_data), .mem_wr_en(mem_wr_en),
    .mem_wr_lanes(mem_wr_lanes), .mem_wr_word(mem_wr_word), .rd_vld(rd_vld),
    .rd_port(rd_port), .rd_lanes(rd_lanes), .mem_rd_word(mem_rd_word),
    .rd_data(rd_data), .rd_ack(rd_ack), .bus_err(bus_err), .mem_err(mem_err),
    .err_flag(err_flag)
  );

  function automatic logic [35:0] encode(logic [31:0] d, logic [3:0] flip);
    logic [35:0] w;
    for (int l = 0; l < 4; l++) begin
      w[9*l +: 8] = d[8*l +: 8];
      w[9*l + 8]  = (($countones(d[8*l +: 8]) % 2) == 0) ^ flip[l];
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] model;
    logic [31:0] d;
    logic [31:0] exp_d;
    logic [7:0] v;
    bit err;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk({err_flag, rd_ack, bus_err, mem_err, mem_wr_en} == 5'b0, "R10",
        {err_flag, rd_ack, bus_err, mem_err, mem_wr_en}, 0);

    // R1 R2: write encoding sweep, report disabled
    for (int vi = 0; vi < 256; vi++) begin
      for (int m = 0; m < 16; m++) begin
        for (int inj = 0; inj < 2; inj++) begin
          v = 8'(vi);
          d = {v + 8'd7, v + 8'd93, v ^ 8'h5A, v};
          wr_en = 1; wr_lanes = 4'(m); wr_data = d; inj_wrong = inj[0];
          @(negedge clk);
          wr_en = 0; inj_wrong = 0;
          chk(mem_wr_en && mem_wr_lanes == 4'(m) &&
              mem_wr_word == encode(d, inj[0] ? 4'hF : 4'h0),
              inj[0] ? "R2" : "R1", {mem_wr_lanes, mem_wr_word},
              {4'(m), encode(d, inj[0] ? 4'hF : 4'h0)});
        end
      end
    end

    // R3: partial write keeps unaddressed lanes, using a lane-honouring array model
    model = '0;
    wr_en = 1; wr_lanes = 4'hF; wr_data = 32'hA1B2C3D4;
    @(negedge clk);
    wr_en = 0;
    for (int l = 0; l < 4; l++) if (mem_wr_lanes[l]) model[9*l +: 9] = mem_wr_word[9*l +: 9];
    wr_en = 1; wr_lanes = 4'b0101; wr_data = 32'h11223344;
    @(negedge clk);
    wr_en = 0;
    for (int l = 0; l < 4; l++) if (mem_wr_lanes[l]) model[9*l +: 9] = mem_wr_word[9*l +: 9];
    rd_vld = 1; rd_port = 0; rpt_en = 1; rd_lanes = 4'hF; mem_rd_word = model;
    @(negedge clk);
    rd_vld = 0; rpt_en = 0;
    exp_d = 32'hA122C344;
    chk(rd_data == exp_d && rd_ack && !bus_err && !mem_err, "R3",
        {rd_ack, bus_err, rd_data}, {2'b10, exp_d});

    // R4 R5 R6 R7 R8 R9: read sweep; each read also clears the flag
    for (int vi = 0; vi < 16; vi++) begin
      for (int ln = 0; ln < 16; ln++) begin
        for (int cr = 0; cr < 16; cr++) begin
          for (int pr = 0; pr < 4; pr++) begin
            v = 8'(vi * 17);
            d = {~v, v + 8'd1, v ^ 8'h3C, v};
            err = |(4'(ln) & 4'(cr));
            rd_vld = 1; rd_lanes = 4'(ln); mem_rd_word = encode(d, 4'(cr));
            rd_port = pr[0]; rpt_en = pr[1];
            flag_wr_en = 1; flag_wr_val = 0;
            @(negedge clk);
            rd_vld = 0; flag_wr_en = 0;
            chk(rd_data == d, "R5", rd_data, d);
            chk(rd_ack == !(err && pr[1]), err ? (pr[1] ? "R6" : "R7") : "R4",
                rd_ack, !(err && pr[1]));
            chk(bus_err == (err && pr[1] && !pr[0]) && mem_err == (err && pr[1] && pr[0]),
                "R6", {bus_err, mem_err}, {err && pr[1] && !pr[0], err && pr[1] && pr[0]});
            chk(err_flag == err, err ? "R9" : "R4", err_flag, err);
          end
        end
      end
    end
    rpt_en = 0;

    // R8: flag set without reporting, then stays through clean reads
    rd_vld = 1; rd_port = 1; rd_lanes = 4'h2; mem_rd_word = encode(32'h0, 4'h2);
    @(negedge clk);
    rd_vld = 0;
    chk(err_flag && rd_ack, "R8", {err_flag, rd_ack}, 2'b11);
    for (int k = 0; k < 3; k++) begin
      rd_vld = 1; rd_lanes = 4'hF; mem_rd_word = encode(32'h12345678, 4'h0);
      @(negedge clk);
      rd_vld = 0;
      chk(err_flag, "R8", err_flag, 1);
    end

    // R9: explicit clear then set by write
    flag_wr_en = 1; flag_wr_val = 0;
    @(negedge clk);
    flag_wr_en = 0;
    chk(!err_flag, "R9", err_flag, 0);
    @(negedge clk);
    chk(!err_flag, "R9", err_flag, 0);
    flag_wr_en = 1; flag_wr_val = 1;
    @(negedge clk);
    flag_wr_en = 0;
    chk(err_flag, "R9", err_flag, 1);

    // R10: reset clears flag
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk({err_flag, rd_ack, bus_err, mem_err, mem_wr_en} == 5'b0, "R10",
        {err_flag, rd_ack, bus_err, mem_err, mem_wr_en}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule